// File: doc/BRIEF.md
# Temperature-Scaled Refresh Interval Timer

This block tells a refresh sequencer when one memory channel is due for its next refresh. A running count of clock cycles is compared against a refresh period. The period is a programmable 16-bit base interval, scaled by a factor that the DRAM reports as a 3-bit temperature code. When the count reaches the period, the block emits a one-cycle refresh-due pulse and the count starts again from zero.

The temperature code is not a binary number. Only five of its eight values mean anything. The other three raise an error flag. For those three values the timer uses the shortest period, so that refreshes still come early rather than late. Scaling is done with shifts of the base interval. The block issues no memory commands and performs no register accesses. A separate sequencer consumes the pulse.

Top module: `refresh_interval_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `refresh_due_o` and `code_error_o` are 0.
- R2: Temperature code 3'b011 gives a refresh period equal to the base interval.
- R3: Temperature code 3'b000 gives a period of the base interval shifted left by two (four times the base).
- R4: Temperature code 3'b001 gives a period of the base interval shifted left by one (twice the base).
- R5: Temperature code 3'b010 gives a period of the base interval shifted right by one (half the base, rounded down).
- R6: Temperature code 3'b110 gives a period of the base interval shifted right by two (a quarter, rounded down).
- R7: Codes 3'b100, 3'b101 and 3'b111 are undefined. One cycle after such a code is presented, `code_error_o` is 1, and the period is the quarter period of R6. For any defined code, `code_error_o` is 0 one cycle later.
- R8: `refresh_due_o` is high for exactly one cycle, and the count restarts at each pulse. The effective period is never less than 2 cycles, so a scaled period of 0 or 1 behaves as 2.
- R9: While `enable_i` is 0, no pulse is produced and the count is held at zero. After `enable_i` rises, the first pulse is observed exactly one period later (the first pulse comes after P clock edges with enable high).
- R10: The period is re-evaluated every cycle. If the code or base changes so that the elapsed count already reaches the new period, a pulse follows at the next edge. Otherwise the running period ends at the new length, counted from the last pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Timer enable; when low, the count is held at zero |
| base_interval_i | input | 16 | Base refresh interval in clock cycles |
| temp_code_i | input | 3 | Temperature code reported by the DRAM |
| refresh_due_o | output | 1 | One-cycle refresh-due pulse |
| code_error_o | output | 1 | High when the previous cycle's code was undefined |

## Verification
A code change and an expiring period can fall in the same cycle. When the code moves to a shorter scale while the elapsed count already exceeds the new period, the re-evaluation and the pulse coincide. The bench provokes this by switching from the four-times code to the quarter code 60 cycles into a 400-cycle period. It judges the result by requiring the pulse at the very next cycle and then a full quarter period to the following pulse. The opposite change is also exercised: lengthening the period in mid-count must delay the pulse to the new length, measured from enable.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

    // Scale selected by the temperature code
    typedef enum logic [2:0] {
        SCALE_QUARTER = 3'd0,
        SCALE_HALF    = 3'd1,
        SCALE_ONE     = 3'd2,
        SCALE_TWO     = 3'd3,
        SCALE_FOUR    = 3'd4
    } scale_e;

    // Smallest period the counter will run, in cycles
    localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/rit_code_decode.sv
module rit_code_decode
    import refresh_timer_pkg::*;
(
    input  logic [2:0] code_i,
    output scale_e     scale_o,
    output logic       undefined_o
);

    always_comb begin
        scale_o     = SCALE_QUARTER;
        undefined_o = 1'b0;
        case (code_i)
            3'b000:  scale_o = SCALE_FOUR;
            3'b001:  scale_o = SCALE_TWO;
            3'b011:  scale_o = SCALE_ONE;
            3'b010:  scale_o = SCALE_HALF;
            3'b110:  scale_o = SCALE_QUARTER;
            default: begin
                // undefined codes fall back to the fastest refresh rate
                scale_o     = SCALE_QUARTER;
                undefined_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rit_period_scale.sv
module rit_period_scale
    import refresh_timer_pkg::*;
#(
    parameter int unsigned BASE_W   = 16,
    parameter int unsigned PERIOD_W = BASE_W + 2
) (
    input  logic [BASE_W-1:0]   base_i,
    input  scale_e              scale_i,
    output logic [PERIOD_W-1:0] period_o
);

    localparam logic [PERIOD_W-1:0] FLOOR = PERIOD_W'(MIN_PERIOD);

    logic [PERIOD_W-1:0] base_ext;
    logic [PERIOD_W-1:0] raw_period;

    assign base_ext = PERIOD_W'(base_i);

    always_comb begin
        case (scale_i)
            SCALE_FOUR:    raw_period = base_ext << 2;
            SCALE_TWO:     raw_period = base_ext << 1;
            SCALE_ONE:     raw_period = base_ext;
            SCALE_HALF:    raw_period = base_ext >> 1;
            default:       raw_period = base_ext >> 2;
        endcase
        period_o = (raw_period < FLOOR) ? FLOOR : raw_period;
    end

endmodule

// File: rtl/rit_interval_counter.sv
module rit_interval_counter
    import refresh_timer_pkg::*;
#(
    parameter int unsigned PERIOD_W = 18
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                pulse_o
);

    typedef struct packed {
        logic [PERIOD_W-1:0] count;
        logic                pulse;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic [PERIOD_W:0] next_count;

    always_comb begin
        state_d    = state_q;
        next_count = {1'b0, state_q.count} + 1'b1;
        if (!enable_i) begin
            state_d.count = '0;
            state_d.pulse = 1'b0;
        end else if (next_count >= {1'b0, period_i}) begin
            // period reached (or already passed after a shortening change)
            state_d.count = '0;
            state_d.pulse = 1'b1;
        end else begin
            state_d.count = next_count[PERIOD_W-1:0];
            state_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse_o = state_q.pulse;

    // pulse lasts exactly one cycle
    assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    // counter restarts from zero after each pulse
    assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> (state_q.count == '0));

    // disabled timer produces no pulse and holds its count
    assert_quiet_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!pulse_o && state_q.count == '0));

endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import refresh_timer_pkg::*;
#(
    parameter int unsigned BASE_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic [BASE_W-1:0] base_interval_i,
    input  logic [2:0]        temp_code_i,
    output logic              refresh_due_o,
    output logic              code_error_o
);

    localparam int unsigned PERIOD_W = BASE_W + 2;

    typedef struct packed {
        logic code_err;
    } top_state_t;

    top_state_t          state_d, state_q;
    scale_e              scale;
    logic                code_undefined;
    logic [PERIOD_W-1:0] period;

    rit_code_decode u_decode (
        .code_i      (temp_code_i),
        .scale_o     (scale),
        .undefined_o (code_undefined)
    );

    rit_period_scale #(
        .BASE_W   (BASE_W),
        .PERIOD_W (PERIOD_W)
    ) u_scale (
        .base_i   (base_interval_i),
        .scale_i  (scale),
        .period_o (period)
    );

    rit_interval_counter #(
        .PERIOD_W (PERIOD_W)
    ) u_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .period_i (period),
        .pulse_o  (refresh_due_o)
    );

    always_comb begin
        state_d          = state_q;
        state_d.code_err = code_undefined;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign code_error_o = state_q.code_err;

    // undefined codes raise the flag one cycle later
    assert_undef_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (temp_code_i inside {3'b100, 3'b101, 3'b111}) |=> code_error_o);

    // defined codes clear the flag one cycle later
    assert_defined_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (temp_code_i inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110}) |=> !code_error_o);

    // undefined codes use the quarter period; the scale never runs slower
    assert_undef_fastest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_undefined |-> (scale == SCALE_QUARTER));

endmodule

// File: tb/refresh_interval_timer_bench.sv
module refresh_interval_timer_bench;

    localparam int NV = 13;
    // base, code, expected period, expected error flag
    localparam int V_BASE [NV] = '{100, 100, 100, 100, 100, 100, 100, 100, 7, 5, 0, 3, 1000};
    localparam int V_CODE [NV] = '{3, 0, 1, 2, 6, 7, 5, 4, 2, 6, 3, 0, 0};
    localparam int V_PER  [NV] = '{100, 400, 200, 50, 25, 25, 25, 25, 3, 2, 2, 12, 4000};
    localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0};
    // Row tags: R2, R3, R4, R5, R6, R7, R7, R7, R5, R8, R8, R3, R3
    localparam string V_REQ [NV] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R7", "R7",
                                     "R5", "R8", "R8", "R3", "R3"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] base = 16'd0;
    logic [2:0]  code = 3'b011;
    logic        due;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    refresh_interval_timer u_refresh_interval_timer (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .enable_i        (enable),
        .base_interval_i (base),
        .temp_code_i     (code),
        .refresh_due_o   (due),
        .code_error_o    (err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!due && n < 6000);
    endtask

    initial begin
        int n;
        int seen;
        repeat (3) @(negedge clk);
        check("R1 due in reset", int'(due), 0);
        check("R1 err in reset", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 due after reset", int'(due), 0);
        check("R1 err after reset", int'(err), 0);

        for (int i = 0; i < NV; i++) begin
            enable = 1'b0;
            base   = 16'(V_BASE[i]);
            code   = 3'(V_CODE[i]);
            repeat (2) @(negedge clk);
            check({V_REQ[i], " error flag"}, int'(err), V_ERR[i]);
            enable = 1'b1;
            wait_pulse(n);
            check({V_REQ[i], " first period"}, n, V_PER[i]);
            @(negedge clk);
            check("R8 pulse width", int'(due), 0);
            wait_pulse(n);
            check({V_REQ[i], " second period"}, n + 1, V_PER[i]);
        end

        // R9: disabled timer stays quiet, then restarts from zero
        enable = 1'b0;
        base   = 16'd10;
        code   = 3'b011;
        seen   = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (due) seen++;
        end
        check("R9 no pulse while disabled", seen, 0);
        enable = 1'b1;
        wait_pulse(n);
        check("R9 first pulse after enable", n, 10);

        // R10: shortening change with elapsed count already past new period
        enable = 1'b0;
        base   = 16'd100;
        code   = 3'b000;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (60) @(negedge clk);
        check("R10 no pulse before change", int'(due), 0);
        code = 3'b110;
        @(negedge clk);
        check("R10 immediate pulse on shortening", int'(due), 1);
        wait_pulse(n);
        check("R10 quarter period after change", n, 25);

        // R10: lengthening change mid-count ends at new length
        enable = 1'b0;
        code   = 3'b110;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        code = 3'b000;
        wait_pulse(n);
        check("R10 lengthened period", n + 10, 400);

        // R7: flag drops one cycle after a defined code returns
        code = 3'b101;
        @(negedge clk);
        check("R7 flag raised", int'(err), 1);
        code = 3'b011;
        @(negedge clk);
        check("R7 flag cleared", int'(err), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule